// File: doc/BRIEF.md
# Bus Time and Split-Timeout Register Block

This block holds the time-related control registers of a serial-bus node. There are four 32-bit registers: cycle time, bus time, split-timeout high and split-timeout low. A free-running cycle counter outside the block supplies its live value on `cyc_live`. The block extends that value with a seconds count that software can read and write. The count advances by 128 whenever a new sample of the cycle time is smaller than the previous one. A bus-time read joins the stored upper field with the top seven bits of the live cycle time.

Register accesses arrive on a single-beat request port that carries a byte offset and a byte length. Every request gets a response exactly one cycle later, with a response code and read data. A write of the cycle time does two things: it sets the block's previous-sample copy, and it asks the external counter to load the same value through a one-cycle strobe. Writes to the other registers are masked to their defined fields.

Top module: `tm_regs`

## Requirements
- R1: After reset, split-timeout-high reads 0, split-timeout-low reads 0x1900_0000 (800 shifted left by 19), the stored bus-time upper field is 0, and the previous cycle-time sample is 0.
- R2: Every cycle with `acc_valid` high is followed on the next cycle by `rsp_valid` high. No response appears without a request. Response codes are 0 for complete, 1 for type error and 2 for address error.
- R3: A request is a type error and changes no register in either of two cases: the offset bits 1:0 are nonzero, or the length is zero or not a multiple of 4. This check takes precedence over the address check.
- R4: An aligned request to any word other than the four mapped ones returns an address error with read data 0, and leaves every register unchanged.
- R5: Word map by byte offset: 0x0 cycle time, 0x4 bus time, 0x8 split-timeout high, 0xC split-timeout low. Only the addressed word is accessed, whatever the length.
- R6: A cycle-time read returns the `cyc_live` value present on the request cycle, and records it as the previous sample.
- R7: A cycle-time write completes, sets the previous sample to the written value, and raises `cyc_load` for exactly one cycle, together with the response, with `cyc_load_val` equal to the written value.
- R8: A bus-time write stores bits 31:7 of the data and forces bits 6:0 of the stored field to zero.
- R9: A bus-time read returns the stored upper field ORed with `cyc_live[31:25]`. The upper field used is the one after any advance from R10 in the same access.
- R10: On a read of the cycle time or the bus time, if `cyc_live` is below the previous sample, the stored upper field increases by 128, modulo 2^32.
- R11: A split-timeout-high write keeps only bits 2:0; the other bits read as zero.
- R12: A split-timeout-low write keeps only bits 31:19; the other bits read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Request present this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | ADDR_W | Byte offset into the register window |
| acc_len | input | LEN_W | Request length in bytes |
| acc_wdata | input | 32 | Write data |
| cyc_live | input | 32 | Live value of the external cycle counter |
| rsp_valid | output | 1 | Response present this cycle |
| rsp_code | output | 2 | 0 complete, 1 type error, 2 address error |
| rsp_rdata | output | 32 | Read data, 0 on errors and writes |
| cyc_load | output | 1 | One-cycle strobe loading the external counter |
| cyc_load_val | output | 32 | Value for the external counter |

## Verification
The assertions assume that `acc_valid` is low while reset is held. They also assume that request fields are stable across the clock edge at which they are sampled. The bench meets both conditions by driving every input on the falling edge and keeping requests idle until reset is released. The wrap checks depend on `cyc_live` being chosen freely from one request to the next. The bench therefore sets it for each access, picking values both below and above the previous sample, including values next to the 32-bit limit. It then predicts the upper field arithmetically.

// File: rtl/tm_pkg.sv
package tm_pkg;

    localparam int unsigned WORD_W    = 32;
    localparam int unsigned EPOCH_LSB = 7;
    localparam int unsigned TOP_BITS  = WORD_W - 25;

    typedef enum logic [1:0] {
        RC_DONE = 2'd0,
        RC_TYPE = 2'd1,
        RC_ADDR = 2'd2
    } rcode_e;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_CYC,
        SEL_BUS,
        SEL_SPH,
        SEL_SPL
    } sel_e;

    localparam int unsigned WORD_CYC = 0;
    localparam int unsigned WORD_BUS = 1;
    localparam int unsigned WORD_SPH = 2;
    localparam int unsigned WORD_SPL = 3;

    localparam logic [WORD_W-1:0] BUS_KEEP = 32'hFFFF_FF80;
    localparam logic [WORD_W-1:0] SPH_KEEP = 32'h0000_0007;
    localparam logic [WORD_W-1:0] SPL_KEEP = 32'hFFF8_0000;
    localparam logic [WORD_W-1:0] EPOCH_STEP = WORD_W'(1) << EPOCH_LSB;

    typedef struct packed {
        logic [WORD_W-1:0] prev;
        logic [WORD_W-1:0] upper;
    } epoch_t;

    typedef struct packed {
        logic [WORD_W-1:0] hi;
        logic [WORD_W-1:0] lo;
    } split_t;

    typedef struct packed {
        logic              valid;
        rcode_e            code;
        logic [WORD_W-1:0] rdata;
        logic              load;
        logic [WORD_W-1:0] load_val;
    } rsp_t;

endpackage

// File: rtl/tm_decode.sv
module tm_decode
    import tm_pkg::*;
#(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned LEN_W  = 10
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [LEN_W-1:0]  len,
    output logic              aligned,
    output sel_e              sel
);
    localparam int unsigned IDX_W = ADDR_W - 2;

    logic [IDX_W-1:0] word;

    always_comb begin
        word    = addr[ADDR_W-1:2];
        aligned = (addr[1:0] == 2'b00) && (len[1:0] == 2'b00) && (|len);
        case (word)
            IDX_W'(WORD_CYC): sel = SEL_CYC;
            IDX_W'(WORD_BUS): sel = SEL_BUS;
            IDX_W'(WORD_SPH): sel = SEL_SPH;
            IDX_W'(WORD_SPL): sel = SEL_SPL;
            default:          sel = SEL_NONE;
        endcase
    end

endmodule

// File: rtl/tm_epoch.sv
module tm_epoch
    import tm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smp_en,
    input  logic [WORD_W-1:0] live,
    input  logic              cyc_wr,
    input  logic              bus_wr,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] bus_view
);
    epoch_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (smp_en) begin
            if (live < st_q.prev) begin
                st_d.upper = st_q.upper + EPOCH_STEP;
            end
            st_d.prev = live;
        end
        if (cyc_wr) begin
            st_d.prev = wdata;
        end
        if (bus_wr) begin
            st_d.upper = wdata & BUS_KEEP;
        end
        bus_view = st_d.upper | {{(WORD_W-TOP_BITS){1'b0}}, live[WORD_W-1:25]};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/tm_split.sv
module tm_split
    import tm_pkg::*;
#(
    parameter int unsigned LO_RESET_UNITS = 800
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hi_wr,
    input  logic              lo_wr,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] hi_val,
    output logic [WORD_W-1:0] lo_val
);
    localparam logic [WORD_W-1:0] LO_RST = WORD_W'(LO_RESET_UNITS) << 19;

    split_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (hi_wr) begin
            st_d.hi = wdata & SPH_KEEP;
        end
        if (lo_wr) begin
            st_d.lo = wdata & SPL_KEEP;
        end
        hi_val = st_q.hi;
        lo_val = st_q.lo;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.hi <= '0;
            st_q.lo <= LO_RST & SPL_KEEP;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/tm_regs.sv
module tm_regs
    import tm_pkg::*;
#(
    parameter int unsigned ADDR_W         = 8,
    parameter int unsigned LEN_W          = 10,
    parameter int unsigned LO_RESET_UNITS = 800
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [LEN_W-1:0]  acc_len,
    input  logic [31:0]       acc_wdata,
    input  logic [31:0]       cyc_live,
    output logic              rsp_valid,
    output logic [1:0]        rsp_code,
    output logic [31:0]       rsp_rdata,
    output logic              cyc_load,
    output logic [31:0]       cyc_load_val
);
    logic              aligned;
    sel_e              sel;
    logic              hit;
    logic              do_rd;
    logic              do_wr;
    logic [WORD_W-1:0] bus_view;
    logic [WORD_W-1:0] sph_val;
    logic [WORD_W-1:0] spl_val;
    rsp_t              rsp_d, rsp_q;

    tm_decode #(
        .ADDR_W (ADDR_W),
        .LEN_W  (LEN_W)
    ) u_dec (
        .addr    (acc_addr),
        .len     (acc_len),
        .aligned (aligned),
        .sel     (sel)
    );

    always_comb begin
        hit   = acc_valid && aligned && (sel != SEL_NONE);
        do_rd = hit && !acc_write;
        do_wr = hit && acc_write;
    end

    tm_epoch u_epoch (
        .clk      (clk),
        .rst_n    (rst_n),
        .smp_en   (do_rd && (sel == SEL_CYC || sel == SEL_BUS)),
        .live     (cyc_live),
        .cyc_wr   (do_wr && sel == SEL_CYC),
        .bus_wr   (do_wr && sel == SEL_BUS),
        .wdata    (acc_wdata),
        .bus_view (bus_view)
    );

    tm_split #(
        .LO_RESET_UNITS (LO_RESET_UNITS)
    ) u_split (
        .clk    (clk),
        .rst_n  (rst_n),
        .hi_wr  (do_wr && sel == SEL_SPH),
        .lo_wr  (do_wr && sel == SEL_SPL),
        .wdata  (acc_wdata),
        .hi_val (sph_val),
        .lo_val (spl_val)
    );

    always_comb begin
        rsp_d          = '0;
        rsp_d.valid    = acc_valid;
        rsp_d.code     = RC_DONE;
        rsp_d.load_val = rsp_q.load_val;
        if (acc_valid) begin
            if (!aligned) begin
                rsp_d.code = RC_TYPE;
            end else if (sel == SEL_NONE) begin
                rsp_d.code = RC_ADDR;
            end
        end
        if (do_rd) begin
            case (sel)
                SEL_CYC: rsp_d.rdata = cyc_live;
                SEL_BUS: rsp_d.rdata = bus_view;
                SEL_SPH: rsp_d.rdata = sph_val;
                SEL_SPL: rsp_d.rdata = spl_val;
                default: rsp_d.rdata = '0;
            endcase
        end
        if (do_wr && sel == SEL_CYC) begin
            rsp_d.load     = 1'b1;
            rsp_d.load_val = acc_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_q <= '0;
        end else begin
            rsp_q <= rsp_d;
        end
    end

    assign rsp_valid    = rsp_q.valid;
    assign rsp_code     = rsp_q.code;
    assign rsp_rdata    = rsp_q.rdata;
    assign cyc_load     = rsp_q.load;
    assign cyc_load_val = rsp_q.load_val;

endmodule

// File: rtl/tm_regs_chk.sv
module tm_regs_chk #(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned LEN_W  = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              acc_valid,
    input logic              acc_write,
    input logic [ADDR_W-1:0] acc_addr,
    input logic [LEN_W-1:0]  acc_len,
    input logic [31:0]       acc_wdata,
    input logic [31:0]       cyc_live,
    input logic              rsp_valid,
    input logic [1:0]        rsp_code,
    input logic [31:0]       rsp_rdata,
    input logic              cyc_load,
    input logic [31:0]       cyc_load_val
);
    logic ok_shape;
    logic [ADDR_W-3:0] w;
    assign ok_shape = (acc_addr[1:0] == 2'b00) && (acc_len[1:0] == 2'b00) && (acc_len != '0);
    assign w = acc_addr[ADDR_W-1:2];

    // R2: one response per request, one cycle later
    p_rsp_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid |=> rsp_valid);
    p_no_spurious_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |=> !rsp_valid);

    // R3: misshaped request yields type error
    p_misaligned_type_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !ok_shape) |=> (rsp_code == 2'd1));

    // R7: load strobe only after a cycle-time write, carrying its data
    p_load_source_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_write && ok_shape && w == '0) |=>
            (cyc_load && cyc_load_val == $past(acc_wdata)));
    p_load_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_load |-> $past(acc_valid && acc_write && ok_shape && w == '0));

    // R9: low seven bits of a bus-time read come from the live cycle time
    p_bus_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !acc_write && ok_shape && w == 1) |=>
            (rsp_rdata[6:0] == $past(cyc_live[31:25])));

    // R11 / R12: split-timeout reads never show bits outside their fields
    p_sph_mask_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !acc_write && ok_shape && w == 2) |=> (rsp_rdata[31:3] == '0));
    p_spl_mask_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !acc_write && ok_shape && w == 3) |=> (rsp_rdata[18:0] == '0));

endmodule

bind tm_regs tm_regs_chk #(
    .ADDR_W (ADDR_W),
    .LEN_W  (LEN_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .acc_valid    (acc_valid),
    .acc_write    (acc_write),
    .acc_addr     (acc_addr),
    .acc_len      (acc_len),
    .acc_wdata    (acc_wdata),
    .cyc_live     (cyc_live),
    .rsp_valid    (rsp_valid),
    .rsp_code     (rsp_code),
    .rsp_rdata    (rsp_rdata),
    .cyc_load     (cyc_load),
    .cyc_load_val (cyc_load_val)
);

// File: tb/sim_tm_regs.sv
`timescale 1ns/1ps
module sim_tm_regs;
    localparam int unsigned ADDR_W = 8;
    localparam int unsigned LEN_W  = 10;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              acc_valid = 1'b0;
    logic              acc_write = 1'b0;
    logic [ADDR_W-1:0] acc_addr = '0;
    logic [LEN_W-1:0]  acc_len = '0;
    logic [31:0]       acc_wdata = '0;
    logic [31:0]       cyc_live = '0;
    logic              rsp_valid;
    logic [1:0]        rsp_code;
    logic [31:0]       rsp_rdata;
    logic              cyc_load;
    logic [31:0]       cyc_load_val;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 0;

    logic [31:0] m_prev, m_up, m_sph, m_slo;

    always #2.5 clk = ~clk;

    tm_regs #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u0 (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
        .acc_addr(acc_addr), .acc_len(acc_len), .acc_wdata(acc_wdata),
        .cyc_live(cyc_live), .rsp_valid(rsp_valid), .rsp_code(rsp_code),
        .rsp_rdata(rsp_rdata), .cyc_load(cyc_load), .cyc_load_val(cyc_load_val)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // one access; expectation from the requirement model
    task automatic run(input bit wr, input logic [ADDR_W-1:0] a, input logic [LEN_W-1:0] l,
                       input logic [31:0] wd, input logic [31:0] live, input string tag);
        logic [1:0]  e_code;
        logic [31:0] e_data;
        bit          e_load;
        int          word;
        e_code = 2'd0; e_data = '0; e_load = 0;
        word = int'(a) >> 2;
        if (a[1:0] != 0 || l[1:0] != 0 || l == 0) begin
            e_code = 2'd1;                              // R3
        end else if (word > 3) begin
            e_code = 2'd2;                              // R4
        end else if (wr) begin
            case (word)
                0: begin m_prev = wd; e_load = 1; end   // R7
                1: m_up  = wd & 32'hFFFF_FF80;          // R8
                2: m_sph = wd & 32'h7;                  // R11
                default: m_slo = wd & 32'hFFF8_0000;    // R12
            endcase
        end else begin
            if (word <= 1) begin
                if (live < m_prev) m_up = m_up + 32'd128; // R10
                m_prev = live;
            end
            case (word)
                0: e_data = live;                        // R6
                1: e_data = m_up | {25'd0, live[31:25]}; // R9
                2: e_data = m_sph;
                default: e_data = m_slo;
            endcase
        end
        @(negedge clk);
        acc_valid = 1; acc_write = wr; acc_addr = a; acc_len = l;
        acc_wdata = wd; cyc_live = live;
        @(posedge clk);
        #1;
        acc_valid = 0;
        chk({tag, " valid R2"}, {31'd0, rsp_valid}, 32'd1);
        chk({tag, " code R2"}, {30'd0, rsp_code}, {30'd0, e_code});
        chk({tag, " data"}, rsp_rdata, e_data);
        chk({tag, " load R7"}, {31'd0, cyc_load}, {31'd0, e_load});
        if (e_load) chk({tag, " load_val R7"}, cyc_load_val, wd);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        m_prev = 0; m_up = 0; m_sph = 0; m_slo = 32'h1900_0000;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        #1;
        chk("reset idle R2", {31'd0, rsp_valid}, 32'd0);

        // R1: reset values
        run(0, 8'h08, 10'd4, 0, 32'h0, "R1 sph");
        run(0, 8'h0C, 10'd4, 0, 32'h0, "R1 slo");
        run(0, 8'h04, 10'd4, 0, 32'h0400_0000, "R1 bus");

        // R4 R5 R6: sweep every aligned word with rising live value
        for (int i = 0; i < 64; i++) begin
            run(0, 8'(i * 4), 10'd4, 0, 32'h0400_0000 + 32'(i) * 32'h0010_0000, "R5 R4 sweep");
        end
        // R5: longer lengths still touch only one word
        run(1, 8'h08, 10'd16, 32'hFFFF_FFFF, 32'h0, "R5 len16 wr");
        run(0, 8'h0C, 10'd8, 0, 32'h0, "R5 len8 rd");

        // R3: misaligned offsets and lengths, then registers unchanged
        for (int o = 1; o < 4; o++) run(1, 8'(8'h0C + o), 10'd4, 32'h0, 32'h0, "R3 addr");
        for (int l = 0; l < 9; l++) begin
            if (l != 4 && l != 8) run(1, 8'h08, 10'(l), 32'h0, 32'h0, "R3 len");
        end
        run(0, 8'h08, 10'd4, 0, 32'h0, "R3 sph kept");
        run(0, 8'h0C, 10'd4, 0, 32'h0, "R3 slo kept");

        // R4: unmapped writes leave state intact
        for (int i = 4; i < 64; i += 7) run(1, 8'(i * 4), 10'd4, 32'hFFFF_FFFF, 32'h0, "R4 wr");
        run(0, 8'h08, 10'd4, 0, 32'h0, "R4 sph kept");
        run(0, 8'h0C, 10'd4, 0, 32'h0, "R4 slo kept");
        run(0, 8'h04, 10'd4, 0, 32'hFFFF_FFFF, "R4 bus kept");

        // R8 R11 R12: write masks under several patterns
        for (int p = 0; p < 8; p++) begin
            logic [31:0] pat;
            pat = 32'hA5C3_96E1 ^ (32'h1111_1111 * 32'(p)) ^ {p[0] ? 32'hFFFF_FFFF : 32'h0};
            run(1, 8'h04, 10'd4, pat, 32'h0, "R8 wr");
            run(0, 8'h04, 10'd4, 0, 32'hFFFF_FFFF, "R8 rd");
            run(1, 8'h08, 10'd4, pat, 32'h0, "R11 wr");
            run(0, 8'h08, 10'd4, 0, 32'h0, "R11 rd");
            run(1, 8'h0C, 10'd4, pat, 32'h0, "R12 wr");
            run(0, 8'h0C, 10'd4, 0, 32'h0, "R12 rd");
        end

        // R7: cycle-time write loads strobe, which drops the next cycle
        run(1, 8'h00, 10'd4, 32'h8000_0000, 32'h0, "R7 wr");
        @(posedge clk); #1;
        chk("R7 strobe low", {31'd0, cyc_load}, 32'd0);
        chk("R2 idle", {31'd0, rsp_valid}, 32'd0);

        // R10: wrap detection from the written sample, via both reads
        run(0, 8'h00, 10'd4, 0, 32'h0000_1000, "R10 cyc wrap");
        run(0, 8'h04, 10'd4, 0, 32'h0000_2000, "R10 bus no wrap");
        run(0, 8'h04, 10'd4, 0, 32'h0000_1FFF, "R10 bus wrap");
        run(0, 8'h04, 10'd4, 0, 32'h0000_1FFF, "R10 equal no wrap");
        // R10: upper field rolls over 2^32
        run(1, 8'h04, 10'd4, 32'hFFFF_FF80, 32'h0, "R10 bus max");
        run(0, 8'h00, 10'd4, 0, 32'hFFFF_FFFF, "R10 high sample");
        run(0, 8'h04, 10'd4, 0, 32'h0, "R10 roll");
        // R10: stepwise sequence of wraps
        for (int k = 0; k < 20; k++) begin
            run(0, 8'((k % 2) * 4), 10'd4, 0, 32'(k % 3) * 32'h5555_5555, "R10 seq");
        end

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule